// File: doc/BRIEF.md
# Stereo Serial Audio Output Serializer

This block turns parallel stereo sample pairs into a three-wire serial audio stream. The three wires are a bit clock, a word select and the serial data. The bit clock comes from the system clock through a divider. It runs at 64 periods per stereo frame, which is 64 times the sample rate. Each frame carries a 32-bit left slot and then a 32-bit right slot. Both slots are sent most significant bit first, in two's complement.

At every frame boundary the block offers a one-cycle ready pulse. If a 24-bit pair is valid in that cycle, the block takes it. It also takes the 2-bit precision select in the same cycle. Each sample is rounded to 16, 18, 20 or 22 bits, with saturation on positive overflow. The rounded value is placed at the top of its slot and the bits below it are filled with zeros. If no pair is offered, the block sends a silent frame and the clocks keep running.

Data and word select change only on a falling bit-clock edge, so a receiver samples them on the rising edge. Word select changes one bit period before the MSB of the channel it marks.

Top module: `stereo_serializer`

## Requirements
- R1: The bit clock `sck` spends HALF system-clock cycles high and HALF cycles low. Two consecutive frame boundaries (`in_ready` pulses) are exactly 64 falling `sck` edges apart.
- R2: Each frame sends the 32-bit left slot and then the 32-bit right slot. Each slot is sent MSB first, one bit per `sck` period.
- R3: Bit periods are numbered 0 to 63 from the left MSB. `ws` is low in periods 0–30 and high in periods 31–62, so it rises one period before the right MSB. `ws` is low again in period 63, one period before the next left MSB.
- R4: `sd` and `ws` change only in the cycle in which `sck` falls.
- R5: `prec_sel` chooses the precision P: 00 = 16, 01 = 18, 10 = 20, 11 = 22 bits. The 24-bit sample gets half an LSB of P added to it, and is then truncated to its upper P bits.
- R6: If rounding overflows a positive sample, the result is the largest positive P-bit code (0 followed by P-1 ones).
- R7: The rounded P-bit value fills slot bits 31 down to 32-P. Slot bits 31-P down to 0 are sent as zero.
- R8: `in_ready` is high for exactly one system-clock cycle per frame, and only in a cycle where `sck` is about to fall. The pair and `prec_sel` are taken in that cycle. Later changes to them have no effect on the frame being sent.
- R9: If `in_valid` is low when `in_ready` is high, the next frame is all zeros. `sck` and `ws` keep their normal pattern.
- R10: While reset is held, `sck`, `ws`, `sd` and `in_ready` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the bit clock is derived from it |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A stereo pair is offered |
| in_ready | output | 1 | One-cycle pulse at a frame boundary; the pair is taken when in_valid is also high |
| in_left | input | IN_W | Left sample, two's complement |
| in_right | input | IN_W | Right sample, two's complement |
| prec_sel | input | 2 | Output precision select |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select, low = left, high = right |
| sd | output | 1 | Serial data, MSB first |

## Verification
Two events can land in the same system-clock cycle: the acceptance of a new pair together with its precision, and the last falling bit-clock edge of the current frame, which shifts out the final right-channel bit. The bench makes them coincide by holding `in_valid` and a precision select until the ready pulse arrives. Right after the handshake it changes `prec_sel` and the sample values. It then rebuilds the next whole frame from the rising `sck` edges, checks the rounded and zero-filled bits against a model that uses the captured select, and checks the `ws` pattern around the boundary.

// File: rtl/stereo_serializer.sv
module stereo_serializer #(
  parameter int IN_W   = 24,
  parameter int SLOT_W = 32,
  parameter int HALF   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IN_W-1:0] in_left,
  input  logic [IN_W-1:0] in_right,
  input  logic [1:0]      prec_sel,
  output logic            sck,
  output logic            ws,
  output logic            sd
);
  localparam int FRAME = 2 * SLOT_W;
  localparam int BW    = $clog2(FRAME);
  localparam int DW    = $clog2(HALF + 1);

  logic [DW-1:0]    div_cnt;
  logic [BW-1:0]    bit_cnt;
  logic [FRAME-1:0] frame_sr;

  wire          tick      = div_cnt == DW'(HALF - 1);
  wire          fall      = tick & sck;
  wire          frame_end = fall & (bit_cnt == BW'(FRAME - 1));
  wire [BW-1:0] nxt_bit   = bit_cnt + 1'b1;

  assign in_ready = frame_end;
  assign sd       = frame_sr[FRAME-1];

  function automatic logic [SLOT_W-1:0] round_slot(input logic [IN_W-1:0] x,
                                                   input logic [1:0] sel);
    int drop;
    logic [IN_W-1:0] half_lsb, keep, sum;
    drop     = IN_W - 16 - 2 * int'(sel);
    half_lsb = IN_W'(1) << (drop - 1);
    keep     = ~((IN_W'(1) << drop) - IN_W'(1));
    sum      = x + half_lsb;
    if (!x[IN_W-1] && sum[IN_W-1])
      sum = {1'b0, {(IN_W-1){1'b1}}};
    return {sum & keep, {(SLOT_W-IN_W){1'b0}}};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      sck      <= 1'b0;
      bit_cnt  <= BW'(FRAME - 1);
      frame_sr <= '0;
      ws       <= 1'b0;
    end else begin
      if (tick) begin
        div_cnt <= '0;
        sck     <= ~sck;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
      if (fall) begin
        bit_cnt <= nxt_bit;
        ws      <= (nxt_bit >= BW'(SLOT_W - 1)) && (nxt_bit != BW'(FRAME - 1));
        if (frame_end)
          frame_sr <= in_valid ? {round_slot(in_left, prec_sel), round_slot(in_right, prec_sel)}
                               : '0;
        else
          frame_sr <= frame_sr << 1;
      end
    end
  end
endmodule

// File: rtl/stereo_serializer_chk.sv
module stereo_serializer_chk #(
  parameter int SLOT_W = 32
) (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic sck,
  input logic ws,
  input logic sd
);
  localparam int CW = $clog2(2 * SLOT_W) + 2;

  logic          sck_q;
  logic          seen;
  logic [CW-1:0] falls;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      seen  <= 1'b0;
      falls <= '0;
    end else begin
      sck_q <= sck;
      if (in_ready) begin
        seen  <= 1'b1;
        falls <= '0;
      end else if (sck_q && !sck) begin
        falls <= falls + 1'b1;
      end
    end
  end

  AST_EDGE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({sd, ws}) |-> $fell(sck)); // R4
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready); // R8
  AST_READY_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> $fell(sck)); // R8
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && seen) |-> (falls == CW'(2 * SLOT_W))); // R1
endmodule

bind stereo_serializer stereo_serializer_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .sck(sck), .ws(ws), .sd(sd));

// File: tb/tb_stereo_serializer.sv
module tb_stereo_serializer;
  localparam int CLK_P = 10;
  localparam int HALF  = 2;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [23:0] in_left = '0, in_right = '0;
  logic [1:0] prec_sel = '0;
  logic in_ready, sck, ws, sd;
  int tests = 0, fails = 0;

  stereo_serializer #(.HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .prec_sel(prec_sel),
    .sck(sck), .ws(ws), .sd(sd));

  always #(CLK_P/2) clk = ~clk;

  localparam logic [63:0] WS_PAT = {31'b0, 32'hFFFF_FFFF, 1'b0};

  logic [63:0] mon_d = '0, mon_w = '0, last_d = '0, last_w = '0;
  logic ws_prev = 1'b0;
  int frames = 0;

  always @(posedge sck) begin
    mon_d = {mon_d[62:0], sd};
    mon_w = {mon_w[62:0], ws};
    if (ws_prev && !ws) begin
      last_d = mon_d;
      last_w = mon_w;
      frames++;
    end
    ws_prev = ws;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  function automatic logic [31:0] ref_slot(logic [23:0] x, logic [1:0] sel);
    int p, d;
    longint v, r, mx;
    p  = 16 + 2 * int'(sel);
    d  = 24 - p;
    v  = longint'($signed(x));
    r  = (v + (longint'(1) << (d - 1))) >>> d;
    mx = (longint'(1) << (p - 1)) - 1;
    if (r > mx) r = mx;
    return 32'(r << (32 - p));
  endfunction

  function automatic logic [31:0] low_mask(logic [1:0] sel);
    return (32'd1 << (16 - 2 * int'(sel))) - 32'd1;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 reset outputs", {60'b0, sck, ws, sd, in_ready}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 ready low after release", {63'b0, in_ready}, 64'd0);
  endtask

  task automatic t_sck_period();
    time t0, t1, t2;
    @(posedge sck) t0 = $time;
    @(negedge sck) t1 = $time;
    @(posedge sck) t2 = $time;
    check("R1 sck high time", 64'(t1 - t0), 64'(HALF * CLK_P));
    check("R1 sck low time",  64'(t2 - t1), 64'(HALF * CLK_P));
  endtask

  task automatic t_pair(logic [23:0] l, logic [23:0] r, logic [1:0] sel,
                        logic [1:0] sel_after, string tag);
    int target;
    logic [63:0] exp;
    in_left = l; in_right = r; prec_sel = sel; in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    target = frames + 1;
    in_valid = 1'b0;
    prec_sel = sel_after;
    in_left  = ~l;
    in_right = ~r;
    wait (frames == target);
    #1;
    exp = {ref_slot(l, sel), ref_slot(r, sel)};
    check({"R2 R5 R6 R8 frame data ", tag}, last_d, exp);
    check({"R7 zero fill ", tag},
          {last_d[63:32] & low_mask(sel), last_d[31:0] & low_mask(sel)}, 64'd0);
    check({"R3 ws pattern ", tag}, last_w, WS_PAT);
  endtask

  task automatic t_idle();
    int start;
    in_valid = 1'b0;
    in_left = 24'h5A5A5A; in_right = 24'hA5A5A5;
    start = frames;
    wait (frames == start + 2);
    #1;
    check("R9 silent frame data", last_d, 64'd0);
    check("R9 ws keeps running", last_w, WS_PAT);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    t_reset();
    t_sck_period();
    t_pair(24'h123480, 24'hFFFF7F, 2'b00, 2'b11, "p16 round");
    t_pair(24'h7FFFFF, 24'h800000, 2'b01, 2'b00, "p18 extremes");
    t_pair(24'h00000F, 24'hABCDEF, 2'b10, 2'b01, "p20 mixed");
    t_pair(24'h7FFFFE, 24'hFFFFFE, 2'b11, 2'b10, "p22 overflow");
    t_pair(24'h000080, 24'hFFFF80, 2'b00, 2'b11, "p16 half");
    t_idle();
    t_pair(24'h3C3C3C, 24'hC3C3C3, 2'b01, 2'b10, "after idle");
    report();
  end
endmodule